// File: doc/BRIEF.md
# Micro-Op Aware Fetch PC Sequencer

This block holds the fetch-side program state of each hardware thread: the address of the instruction being fetched, the address that follows it, and an index that points at the current micro-op inside a macro-instruction. When the fetch unit presents one instruction or micro-op for a thread, the block computes the triple that fetch will use next. It returns that triple at once as the predicted target of the instruction, together with a predicted-taken bit, and stores it on the next clock edge. The direction and target of a branch come from an external predictor.

Redirects from the decode and commit stages overwrite a thread's triple with the values that arrive with them. A commit redirect outranks a decode redirect. A thread that took a redirect in the previous cycle is marked as squashing and ignores decode redirects for that cycle. Each thread also has a flag that marks a pending instruction-cache miss, and any applied redirect clears that flag.

Top module: `uop_pc_seq`

## Requirements
- R1: After reset every thread holds pc = 0, npc = 4, micro-op index = 0, with its squashing bit and icache-wait bit both 0.
- R2: A non-control micro-op that is not the last one (adv_ctrl=0, adv_uop=1, adv_last=0) keeps pc and npc, increments the micro-op index by one and reports pred_taken = 0.
- R3: Any other non-control instruction moves pc to the old npc, sets npc to the old npc + 4, clears the micro-op index and reports pred_taken = 0.
- R4: A control instruction with bp_taken = 1 sets pc = bp_target, npc = bp_target + 4, micro-op index = 0 and reports pred_taken = 1.
- R5: A control instruction with bp_taken = 0 moves pc to the old npc, sets npc to the old npc + 4, clears the micro-op index and reports pred_taken = 0.
- R6: cur_* show the stored triple of thread adv_tid, and pred_* show the computed triple in the same cycle. On the next edge the triple is stored for adv_tid only when adv_valid = 1, and every other thread keeps its state.
- R7: A commit redirect loads pc, npc and index from cmt_sq_* into thread cmt_sq_tid on the next edge. It takes effect even while that thread is squashing, and it wins over a decode redirect or an advance for the same thread in the same cycle.
- R8: A decode redirect loads dec_sq_* into thread dec_sq_tid unless that thread has a commit redirect in the same cycle or its squashing bit is set. squashing[t] is 1 in exactly the cycle after a redirect was applied to thread t.
- R9: icache_wait[t] is set by miss_req for t and cleared by miss_done for t or by any redirect applied to t. A redirect wins over a miss_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | An instruction or micro-op is fetched this cycle |
| adv_tid | input | TID_W | Thread of the fetched instruction, also selects cur_* |
| adv_ctrl | input | 1 | Instruction is control flow |
| adv_uop | input | 1 | Instruction is a micro-op |
| adv_last | input | 1 | Micro-op is the last of its macro-instruction |
| bp_taken | input | 1 | Predictor says taken |
| bp_target | input | 32 | Predicted target address |
| cmt_sq_valid | input | 1 | Commit redirect |
| cmt_sq_tid | input | TID_W | Commit redirect thread |
| cmt_sq_pc | input | 32 | Commit redirect pc |
| cmt_sq_npc | input | 32 | Commit redirect npc |
| cmt_sq_uidx | input | 6 | Commit redirect micro-op index |
| dec_sq_valid | input | 1 | Decode redirect |
| dec_sq_tid | input | TID_W | Decode redirect thread |
| dec_sq_pc | input | 32 | Decode redirect pc |
| dec_sq_npc | input | 32 | Decode redirect npc |
| dec_sq_uidx | input | 6 | Decode redirect micro-op index |
| miss_req_valid | input | 1 | An icache miss starts |
| miss_req_tid | input | TID_W | Thread of the miss |
| miss_done_valid | input | 1 | An icache miss returns |
| miss_done_tid | input | TID_W | Thread of the returning miss |
| cur_pc | output | 32 | Stored pc of thread adv_tid |
| cur_npc | output | 32 | Stored npc of thread adv_tid |
| cur_uidx | output | 6 | Stored micro-op index of thread adv_tid |
| pred_pc | output | 32 | Predicted next pc |
| pred_npc | output | 32 | Predicted next npc |
| pred_uidx | output | 6 | Predicted next micro-op index |
| pred_taken | output | 1 | Predicted taken |
| squashing | output | NUM_THREADS | Per-thread squashing bit |
| icache_wait | output | NUM_THREADS | Per-thread pending miss bit |

## Verification
The bench applies all sixteen combinations of control, micro-op, last and taken to every thread. The order matters: a control instruction arrives while the micro-op index is non-zero, so a design that keeps the index across a branch shows a wrong pred_uidx. After every step the neighbouring thread is read back, which exposes a write-enable decode that touches the wrong thread. The redirect sequences cover several cases: a commit and a decode redirect to the same thread in one cycle, where a wrong priority stores the decode values; a decode redirect in the cycle after a redirect, which must be dropped; and a redirect that meets a new miss in the same cycle, where a wrong order leaves icache_wait set.

// File: rtl/uop_pc_pkg.sv
package uop_pc_pkg;
  parameter int unsigned PC_W       = 32;
  parameter int unsigned UIDX_W     = 6;
  parameter int unsigned INST_BYTES = 4;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [UIDX_W-1:0] uidx_t;

  typedef struct packed {
    pc_t   pc;
    pc_t   npc;
    uidx_t uidx;
  } triple_t;

  localparam pc_t     STEP_BYTES   = pc_t'(INST_BYTES);
  localparam triple_t RESET_TRIPLE = '{pc: '0, npc: STEP_BYTES, uidx: '0};

  typedef enum logic [1:0] {
    STEP_SEQ   = 2'd0,
    STEP_UOP   = 2'd1,
    STEP_TAKEN = 2'd2,
    STEP_FALL  = 2'd3
  } step_e;
endpackage

// File: rtl/uop_rst_sync.sv
module uop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/uop_next_calc.sv
module uop_next_calc import uop_pc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  triple_t cur,
  input  logic    is_ctrl,
  input  logic    is_uop,
  input  logic    is_last,
  input  logic    bp_taken,
  input  pc_t     bp_target,
  output triple_t nxt,
  output logic    taken
);
  step_e step;

  always_comb begin
    if (is_ctrl)                step = bp_taken ? STEP_TAKEN : STEP_FALL;
    else if (is_uop && !is_last) step = STEP_UOP;
    else                        step = STEP_SEQ;
  end

  always_comb begin
    nxt   = cur;
    taken = 1'b0;
    unique case (step)
      STEP_UOP: begin
        nxt.uidx = cur.uidx + uidx_t'(1);
      end
      STEP_TAKEN: begin
        nxt.pc   = bp_target;
        nxt.npc  = bp_target + STEP_BYTES;
        nxt.uidx = '0;
        taken    = 1'b1;
      end
      default: begin
        nxt.pc   = cur.npc;
        nxt.npc  = cur.npc + STEP_BYTES;
        nxt.uidx = '0;
      end
    endcase
  end

  assert_mid_uop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ctrl && is_uop && !is_last) |->
      (nxt.pc == cur.pc && nxt.npc == cur.npc &&
       nxt.uidx == uidx_t'(cur.uidx + uidx_t'(1)) && !taken));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ctrl && !(is_uop && !is_last)) |->
      (nxt.pc == cur.npc && nxt.uidx == '0 && !taken));

  assert_taken_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && bp_taken) |-> (nxt.pc == bp_target && nxt.uidx == '0 && taken));

  assert_fall_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && !bp_taken) |-> (nxt.pc == cur.npc && nxt.uidx == '0 && !taken));
endmodule

// File: rtl/uop_squash_arb.sv
module uop_squash_arb import uop_pc_pkg::*; #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned TID_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmt_valid,
  input  logic [TID_W-1:0] cmt_tid,
  input  triple_t          cmt_val,
  input  logic             dec_valid,
  input  logic [TID_W-1:0] dec_tid,
  input  triple_t          dec_val,
  input  logic [NUM_THREADS-1:0] squashing,
  output logic [NUM_THREADS-1:0] sq_en,
  output triple_t          sq_val [NUM_THREADS]
);
  logic [NUM_THREADS-1:0] cmt_hit;
  logic [NUM_THREADS-1:0] dec_hit;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      cmt_hit[t] = cmt_valid && (cmt_tid == TID_W'(t));
      dec_hit[t] = dec_valid && (dec_tid == TID_W'(t)) && !squashing[t] && !cmt_hit[t];
      sq_en[t]   = cmt_hit[t] || dec_hit[t];
      sq_val[t]  = cmt_hit[t] ? cmt_val : dec_val;
    end

    assert_commit_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && cmt_tid == TID_W'(t)) |-> (sq_en[t] && sq_val[t] == cmt_val));

    assert_dec_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_tid == TID_W'(t) && squashing[t] &&
       !(cmt_valid && cmt_tid == TID_W'(t))) |-> !sq_en[t]);
  end
endmodule

// File: rtl/uop_thread_regs.sv
module uop_thread_regs import uop_pc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv_en,
  input  triple_t adv_val,
  input  logic    sq_en,
  input  triple_t sq_val,
  input  logic    miss_set,
  input  logic    miss_clr,
  output triple_t st,
  output logic    squashing,
  output logic    miss_wait
);
  triple_t st_q, st_d;
  logic    st_en;
  logic    sqf_q, sqf_d;
  logic    miss_q, miss_d;

  always_comb begin
    st_en = sq_en || adv_en;
    st_d  = sq_en ? sq_val : adv_val;
    sqf_d = sq_en;
    if (sq_en || miss_clr) miss_d = 1'b0;
    else if (miss_set)     miss_d = 1'b1;
    else                   miss_d = miss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RESET_TRIPLE;
      sqf_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      sqf_q  <= sqf_d;
      miss_q <= miss_d;
    end
  end

  assign st        = st_q;
  assign squashing = sqf_q;
  assign miss_wait = miss_q;

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_en && !adv_en) |=> (st_q == $past(st_q)));

  assert_squash_over_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && adv_en) |=> (st_q == $past(sq_val)));

  assert_squash_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |=> squashing);

  assert_squash_clears_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |=> !miss_wait);
endmodule

// File: rtl/uop_pc_seq.sv
module uop_pc_seq import uop_pc_pkg::*; #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_valid,
  input  logic [TID_W-1:0]       adv_tid,
  input  logic                   adv_ctrl,
  input  logic                   adv_uop,
  input  logic                   adv_last,
  input  logic                   bp_taken,
  input  logic [PC_W-1:0]        bp_target,
  input  logic                   cmt_sq_valid,
  input  logic [TID_W-1:0]       cmt_sq_tid,
  input  logic [PC_W-1:0]        cmt_sq_pc,
  input  logic [PC_W-1:0]        cmt_sq_npc,
  input  logic [UIDX_W-1:0]      cmt_sq_uidx,
  input  logic                   dec_sq_valid,
  input  logic [TID_W-1:0]       dec_sq_tid,
  input  logic [PC_W-1:0]        dec_sq_pc,
  input  logic [PC_W-1:0]        dec_sq_npc,
  input  logic [UIDX_W-1:0]      dec_sq_uidx,
  input  logic                   miss_req_valid,
  input  logic [TID_W-1:0]       miss_req_tid,
  input  logic                   miss_done_valid,
  input  logic [TID_W-1:0]       miss_done_tid,
  output logic [PC_W-1:0]        cur_pc,
  output logic [PC_W-1:0]        cur_npc,
  output logic [UIDX_W-1:0]      cur_uidx,
  output logic [PC_W-1:0]        pred_pc,
  output logic [PC_W-1:0]        pred_npc,
  output logic [UIDX_W-1:0]      pred_uidx,
  output logic                   pred_taken,
  output logic [NUM_THREADS-1:0] squashing,
  output logic [NUM_THREADS-1:0] icache_wait
);
  logic    rst_int_n;
  triple_t st   [NUM_THREADS];
  triple_t sq_val [NUM_THREADS];
  logic [NUM_THREADS-1:0] sq_en;
  triple_t cur, nxt, cmt_val, dec_val;

  uop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_int_n)
  );

  assign cmt_val = '{pc: cmt_sq_pc, npc: cmt_sq_npc, uidx: cmt_sq_uidx};
  assign dec_val = '{pc: dec_sq_pc, npc: dec_sq_npc, uidx: dec_sq_uidx};

  uop_squash_arb #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_arb (
    .clk(clk), .rst_n(rst_int_n),
    .cmt_valid(cmt_sq_valid), .cmt_tid(cmt_sq_tid), .cmt_val(cmt_val),
    .dec_valid(dec_sq_valid), .dec_tid(dec_sq_tid), .dec_val(dec_val),
    .squashing(squashing), .sq_en(sq_en), .sq_val(sq_val)
  );

  assign cur = st[adv_tid];

  uop_next_calc u_calc (
    .clk(clk), .rst_n(rst_int_n), .cur(cur),
    .is_ctrl(adv_ctrl), .is_uop(adv_uop), .is_last(adv_last),
    .bp_taken(bp_taken), .bp_target(bp_target),
    .nxt(nxt), .taken(pred_taken)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic adv_hit, mset, mclr;
    always_comb begin
      adv_hit = adv_valid && (adv_tid == TID_W'(t));
      mset    = miss_req_valid && (miss_req_tid == TID_W'(t));
      mclr    = miss_done_valid && (miss_done_tid == TID_W'(t));
    end
    uop_thread_regs u_regs (
      .clk(clk), .rst_n(rst_int_n),
      .adv_en(adv_hit), .adv_val(nxt),
      .sq_en(sq_en[t]), .sq_val(sq_val[t]),
      .miss_set(mset), .miss_clr(mclr),
      .st(st[t]), .squashing(squashing[t]), .miss_wait(icache_wait[t])
    );
  end

  assign cur_pc    = cur.pc;
  assign cur_npc   = cur.npc;
  assign cur_uidx  = cur.uidx;
  assign pred_pc   = nxt.pc;
  assign pred_npc  = nxt.npc;
  assign pred_uidx = nxt.uidx;

  assert_commit_load_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmt_sq_valid && !adv_valid) |=>
      (st[$past(cmt_sq_tid)].pc == $past(cmt_sq_pc) &&
       st[$past(cmt_sq_tid)].uidx == $past(cmt_sq_uidx)));

  assert_noctrl_not_taken_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_valid && !adv_ctrl) |-> !pred_taken);
endmodule

// File: tb/sim_uop_pc_seq.sv
module sim_uop_pc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        adv_valid = 0, adv_ctrl = 0, adv_uop = 0, adv_last = 0, bp_taken = 0;
  logic [1:0]  adv_tid = 0, cmt_sq_tid = 0, dec_sq_tid = 0, miss_req_tid = 0, miss_done_tid = 0;
  logic [31:0] bp_target = 0, cmt_sq_pc = 0, cmt_sq_npc = 0, dec_sq_pc = 0, dec_sq_npc = 0;
  logic [5:0]  cmt_sq_uidx = 0, dec_sq_uidx = 0;
  logic        cmt_sq_valid = 0, dec_sq_valid = 0, miss_req_valid = 0, miss_done_valid = 0;
  logic [31:0] cur_pc, cur_npc, pred_pc, pred_npc;
  logic [5:0]  cur_uidx, pred_uidx;
  logic        pred_taken;
  logic [3:0]  squashing, icache_wait;

  uop_pc_seq u0 (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] m_pc [4];
  logic [31:0] m_npc [4];
  logic [5:0]  m_ui [4];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(int t, string req);
    adv_tid = 2'(t);
    #1;
    chk(req, {32'b0, cur_pc}, {32'b0, m_pc[t]});
    chk(req, {32'b0, cur_npc}, {32'b0, m_npc[t]});
    chk(req, {58'b0, cur_uidx}, {58'b0, m_ui[t]});
  endtask

  task automatic do_adv(int t, bit c, bit u, bit l, bit tk, logic [31:0] tgt);
    logic [31:0] ep, en;
    logic [5:0] eu;
    bit et;
    string rq;
    if (c) begin
      eu = 0; et = tk; rq = tk ? "R4" : "R5";
      if (tk) begin ep = tgt; en = tgt + 4; end
      else    begin ep = m_npc[t]; en = m_npc[t] + 4; end
    end else if (u && !l) begin
      ep = m_pc[t]; en = m_npc[t]; eu = m_ui[t] + 6'd1; et = 0; rq = "R2";
    end else begin
      ep = m_npc[t]; en = m_npc[t] + 4; eu = 0; et = 0; rq = "R3";
    end
    adv_valid = 1; adv_tid = 2'(t); adv_ctrl = c; adv_uop = u; adv_last = l;
    bp_taken = tk; bp_target = tgt;
    #1;
    chk("R6", {32'b0, cur_pc}, {32'b0, m_pc[t]});
    chk(rq, {pred_pc, pred_npc}, {ep, en});
    chk(rq, {57'b0, pred_taken, pred_uidx}, {57'b0, et, eu});
    tick();
    adv_valid = 0;
    m_pc[t] = ep; m_npc[t] = en; m_ui[t] = eu;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int t = 0; t < 4; t++) begin m_pc[t] = 0; m_npc[t] = 4; m_ui[t] = 0; end
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    repeat (3) tick();

    // R1: reset state of every thread
    for (int t = 0; t < 4; t++) peek(t, "R1");
    chk("R1", {60'b0, squashing}, 64'd0);
    chk("R1", {60'b0, icache_wait}, 64'd0);

    // R2..R6: full sweep of class flags and taken per thread
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 16; k++) begin
        do_adv(t, k[3], k[1], k[0], k[2], 32'h1000 * (t + 1) + 32'(k * 16));
        peek(t, "R6");
        peek(t ^ 1, "R6");
      end
    end

    // R2/R3: a run of micro-ops, closed by the last one
    do_adv(2, 0, 1, 0, 0, 0);
    do_adv(2, 0, 1, 0, 1, 32'hdead0000);
    do_adv(2, 0, 1, 0, 0, 0);
    do_adv(2, 0, 1, 1, 0, 0);
    peek(2, "R3");
    // R6: no advance without adv_valid
    adv_ctrl = 1; bp_taken = 1; bp_target = 32'h4444; adv_tid = 2;
    tick();
    peek(2, "R6");
    adv_ctrl = 0; bp_taken = 0;

    // R7: commit and decode and advance for thread 0 in one cycle
    cmt_sq_valid = 1; cmt_sq_tid = 0; cmt_sq_pc = 32'hA000; cmt_sq_npc = 32'hA004; cmt_sq_uidx = 3;
    dec_sq_valid = 1; dec_sq_tid = 0; dec_sq_pc = 32'hB000; dec_sq_npc = 32'hB004; dec_sq_uidx = 5;
    adv_valid = 1; adv_tid = 0; adv_ctrl = 1; bp_taken = 1; bp_target = 32'hC000;
    miss_req_valid = 1; miss_req_tid = 1;
    tick();
    cmt_sq_valid = 0; adv_valid = 0; adv_ctrl = 0; bp_taken = 0; miss_req_valid = 0;
    m_pc[0] = 32'hA000; m_npc[0] = 32'hA004; m_ui[0] = 3;
    peek(0, "R7");
    chk("R8", {63'b0, squashing[0]}, 64'd1);
    chk("R9", {63'b0, icache_wait[1]}, 64'd1);

    // R8: decode redirect in the squashing cycle is dropped
    dec_sq_tid = 0; dec_sq_pc = 32'hD000; dec_sq_npc = 32'hD004; dec_sq_uidx = 1;
    tick();
    peek(0, "R8");
    chk("R8", {63'b0, squashing[0]}, 64'd0);

    // R8: the same decode redirect now applies
    tick();
    dec_sq_valid = 0;
    m_pc[0] = 32'hD000; m_npc[0] = 32'hD004; m_ui[0] = 1;
    peek(0, "R8");
    chk("R8", {63'b0, squashing[0]}, 64'd1);

    // R8: thread 0 squashing, decode to 0 dropped; commit to 1 applies and clears miss (R9)
    cmt_sq_valid = 1; cmt_sq_tid = 1; cmt_sq_pc = 32'hE000; cmt_sq_npc = 32'hE008; cmt_sq_uidx = 2;
    dec_sq_valid = 1; dec_sq_tid = 0; dec_sq_pc = 32'hF000; dec_sq_npc = 32'hF004; dec_sq_uidx = 0;
    tick();
    cmt_sq_valid = 0;
    m_pc[1] = 32'hE000; m_npc[1] = 32'hE008; m_ui[1] = 2;
    peek(0, "R8");
    peek(1, "R7");
    chk("R9", {63'b0, icache_wait[1]}, 64'd0);
    chk("R8", {60'b0, squashing}, 64'b0010);

    // R8: decode to thread 2 while thread 1 squashes
    dec_sq_tid = 2; dec_sq_pc = 32'h2200; dec_sq_npc = 32'h2204; dec_sq_uidx = 4;
    tick();
    dec_sq_valid = 0;
    m_pc[2] = 32'h2200; m_npc[2] = 32'h2204; m_ui[2] = 4;
    peek(2, "R8");

    // R7: commit applies while thread 2 is squashing; R9 redirect beats a new miss
    cmt_sq_valid = 1; cmt_sq_tid = 2; cmt_sq_pc = 32'h3300; cmt_sq_npc = 32'h3304; cmt_sq_uidx = 0;
    miss_req_valid = 1; miss_req_tid = 2;
    tick();
    cmt_sq_valid = 0; miss_req_valid = 0;
    m_pc[2] = 32'h3300; m_npc[2] = 32'h3304; m_ui[2] = 0;
    peek(2, "R7");
    chk("R9", {63'b0, icache_wait[2]}, 64'd0);

    // R9: miss set, then cleared by miss_done
    miss_req_valid = 1; miss_req_tid = 3;
    tick();
    miss_req_valid = 0;
    chk("R9", {63'b0, icache_wait[3]}, 64'd1);
    tick();
    chk("R9", {63'b0, icache_wait[3]}, 64'd1);
    miss_done_valid = 1; miss_done_tid = 3;
    tick();
    miss_done_valid = 0;
    chk("R9", {63'b0, icache_wait[3]}, 64'd0);

    // R9: decode redirect clears a pending miss
    miss_req_valid = 1; miss_req_tid = 3;
    tick();
    miss_req_valid = 0;
    dec_sq_valid = 1; dec_sq_tid = 3; dec_sq_pc = 32'h5500; dec_sq_npc = 32'h5504; dec_sq_uidx = 7;
    tick();
    dec_sq_valid = 0;
    m_pc[3] = 32'h5500; m_npc[3] = 32'h5504; m_ui[3] = 7;
    chk("R9", {63'b0, icache_wait[3]}, 64'd0);
    peek(3, "R8");

    // R4 after a redirect: branch from the loaded state
    do_adv(3, 1, 0, 0, 1, 32'h7770);
    peek(3, "R4");

    finish_run();
  end
endmodule